// File: doc/BRIEF.md
# Configurable GPIO Port Pin Resolver

This block models one 16-pin general-purpose I/O port. Software sets each pin's direction, its driver type and its pull resistor through a small word-addressed register bus. Software also writes the output data there. Every pin also has an external stimulus: it is either connected and driven to a level, or left unconnected. On every clock edge the port works out a resolved level for each pin from its configuration, its output data and its stimulus. It stores that level in the input-data register and presents it on the pin's output line.

A pin for which no rule yields a level keeps the level it last had. A connected output pin that an external source fights is flagged on a per-pin conflict line. From then on it is resolved as if it were unconnected. The register bus is a plain single-cycle interface with no back-pressure: every write is taken on the edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`.

Top module: `gpr_port`

## Requirements
- R1: A pin is in output mode only when its 2-bit field in the mode register (bits 2i+1:2i) holds 01. The codes 00, 10 and 11 all behave as input mode.
- R2: In output mode with output-type bit 0 (push-pull), or with output-type bit 1 (open-drain) and output-data bit 0, the resolved bit equals the output-data bit.
- R3: In open-drain output mode with output-data bit 1, the resolved bit depends on how the pin is seen. If it is seen as unconnected, it reads 1 with pull code 01, reads 0 with pull code 10, and keeps its value otherwise. If it is connected and driven low, it reads 0.
- R4: In input mode, a connected pin reads its external level. An unconnected pin reads 1 with pull code 01 (bits 2i+1:2i of the pull register) and 0 with pull code 10.
- R5: A pin whose level no rule defines (for example input mode, unconnected, pull code 00 or 11) keeps its previous resolved bit.
- R6: A connected output-mode pin raises its conflict bit if it is push-pull, or if it is open-drain and driven high externally. That pin is then resolved as unconnected. No pin in input mode raises its conflict bit.
- R7: Register map: mode 0x00, output type 0x04, speed 0x08, pull 0x0C, input data 0x10, output data 0x14. Writes to 0x10 and to 0x1C, 0x20, 0x24 and 0x2C have no effect. Those last four read 0.
- R8: After reset every register, every output line and every conflict bit is 0.
- R9: Pin outputs and conflict bits update on the first clock edge after the stimulus or register contents change. A read of 0x10 returns the current pin outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address within the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ext_conn | input | 16 | Per-pin: 1 when an external source is attached |
| ext_high | input | 16 | Per-pin external level when attached |
| pin_out | output | 16 | Resolved per-pin output lines |
| pin_conflict | output | 16 | Per-pin external/output drive clash |

## Verification
A register write lands on the edge where `bus_wr` is sampled. Its effect on `pin_out` and `pin_conflict` appears one edge later. A change in external stimulus shows after a single edge. The bench drives everything at the falling edge and advances a cycle-accurate model at each rising edge, using the values that were present before that edge. It compares at the next falling edge. One directed case also confirms that an output has not moved before its due edge.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  localparam logic [9:0] OFF_MODE  = 10'h000;
  localparam logic [9:0] OFF_OTYPE = 10'h004;
  localparam logic [9:0] OFF_SPEED = 10'h008;
  localparam logic [9:0] OFF_PULL  = 10'h00C;
  localparam logic [9:0] OFF_IDR   = 10'h010;
  localparam logic [9:0] OFF_ODR   = 10'h014;

  localparam logic [1:0] MODE_OUT = 2'b01;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;
endpackage

// File: rtl/gpr_regs.sv
`timescale 1ns/1ps
module gpr_regs
  import gpr_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic [NPINS-1:0]   idr_in,
  output logic [DW-1:0]      bus_rdata,
  output logic [2*NPINS-1:0] mode_q,
  output logic [NPINS-1:0]   otype_q,
  output logic [2*NPINS-1:0] pull_q,
  output logic [NPINS-1:0]   odr_q
);
  localparam int MW = 2 * NPINS;

  logic [DW-1:0] speed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(OFF_MODE):  mode_q  <= bus_wdata[MW-1:0];
        AW'(OFF_OTYPE): otype_q <= bus_wdata[NPINS-1:0];
        AW'(OFF_SPEED): speed_q <= bus_wdata;
        AW'(OFF_PULL):  pull_q  <= bus_wdata[MW-1:0];
        AW'(OFF_ODR):   odr_q   <= bus_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFF_MODE):  bus_rdata[MW-1:0]    = mode_q;
      AW'(OFF_OTYPE): bus_rdata[NPINS-1:0] = otype_q;
      AW'(OFF_SPEED): bus_rdata            = speed_q;
      AW'(OFF_PULL):  bus_rdata[MW-1:0]    = pull_q;
      AW'(OFF_IDR):   bus_rdata[NPINS-1:0] = idr_in;
      AW'(OFF_ODR):   bus_rdata[NPINS-1:0] = odr_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpr_conflict.sv
`timescale 1ns/1ps
module gpr_conflict
  import gpr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       otype,
  input  logic       conn,
  input  logic       high,
  output logic       clash
);
  // An attached source fights an actively driven output stage.
  assign clash = conn && (mode == MODE_OUT) && (!otype || high);
endmodule

// File: rtl/gpr_pin_resolve.sv
`timescale 1ns/1ps
module gpr_pin_resolve
  import gpr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       otype,
  input  logic [1:0] pull,
  input  logic       odr,
  input  logic       disc,
  input  logic       high,
  output logic       defined,
  output logic       level
);
  logic up, down;
  assign up   = (pull == PULL_UP);
  assign down = (pull == PULL_DOWN);

  always_comb begin
    defined = 1'b0;
    level   = 1'b0;
    if (mode == MODE_OUT) begin
      if (!otype || !odr) begin
        defined = 1'b1;
        level   = odr;
      end else if (disc) begin
        defined = up | down;
        level   = up;
      end else if (!high) begin
        defined = 1'b1;
        level   = 1'b0;
      end
    end else if (!disc) begin
      defined = 1'b1;
      level   = high;
    end else begin
      defined = up | down;
      level   = up;
    end
  end
endmodule

// File: rtl/gpr_port.sv
`timescale 1ns/1ps
module gpr_port
  import gpr_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] ext_conn,
  input  logic [NPINS-1:0] ext_high,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_conflict
);
  logic [2*NPINS-1:0] mode_q, pull_q;
  logic [NPINS-1:0]   otype_q, odr_q;
  logic [NPINS-1:0]   idr_q, conf_q;
  logic [NPINS-1:0]   clash_w, def_w, lvl_w;

  gpr_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .idr_in(idr_q), .bus_rdata(bus_rdata),
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q), .odr_q(odr_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpr_conflict u_cf (
      .mode(mode_q[2*i +: 2]), .otype(otype_q[i]),
      .conn(ext_conn[i]), .high(ext_high[i]), .clash(clash_w[i])
    );
    gpr_pin_resolve u_rs (
      .mode(mode_q[2*i +: 2]), .otype(otype_q[i]), .pull(pull_q[2*i +: 2]),
      .odr(odr_q[i]), .disc(~ext_conn[i] | clash_w[i]), .high(ext_high[i]),
      .defined(def_w[i]), .level(lvl_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q  <= '0;
      conf_q <= '0;
    end else begin
      idr_q  <= (idr_q & ~def_w) | (lvl_w & def_w);
      conf_q <= clash_w;
    end
  end

  assign pin_out      = idr_q;
  assign pin_conflict = conf_q;
endmodule

// File: rtl/gpr_port_chk.sv
`timescale 1ns/1ps
module gpr_port_chk #(
  parameter int NPINS = 16,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_rdata,
  input logic [NPINS-1:0]   ext_conn,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_conflict,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   otype_q,
  input logic [2*NPINS-1:0] pull_q,
  input logic [NPINS-1:0]   odr_q
);
  logic [NPINS-1:0] out_m, pp_m, float_m, pu_disc_m;
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      out_m[i]     = (mode_q[2*i +: 2] == 2'b01);
      pp_m[i]      = out_m[i] && !otype_q[i];
      float_m[i]   = !out_m[i] && !ext_conn[i] &&
                     (pull_q[2*i +: 2] != 2'b01) && (pull_q[2*i +: 2] != 2'b10);
      pu_disc_m[i] = !out_m[i] && !ext_conn[i] && (pull_q[2*i +: 2] == 2'b01);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_conflict == '0)); // R8

  AST_IDR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(10'h010)) |-> (bus_rdata == DW'(pin_out))); // R9

  AST_PP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out & $past(pp_m)) == ($past(odr_q) & $past(pp_m)))); // R2

  AST_NO_INPUT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_conflict & ~$past(out_m)) == '0)); // R6

  AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & $past(float_m)) == '0)); // R5

  AST_INPUT_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_out & $past(pu_disc_m)) == $past(pu_disc_m))); // R4

  AST_LOCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(10'h01C)) |=>
      ($stable(mode_q) && $stable(otype_q) && $stable(pull_q) && $stable(odr_q))); // R7
endmodule

bind gpr_port gpr_port_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ext_conn(ext_conn), .pin_out(pin_out),
  .pin_conflict(pin_conflict), .mode_q(mode_q), .otype_q(otype_q),
  .pull_q(pull_q), .odr_q(odr_q)
);

// File: tb/gpr_port_bench.sv
`timescale 1ns/1ps
module gpr_port_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] ext_conn = '0, ext_high = '0;
  logic [N-1:0] pin_out, pin_conflict;

  gpr_port u_gpr_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_conn(ext_conn),
    .ext_high(ext_high), .pin_out(pin_out), .pin_conflict(pin_conflict)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_mode, m_pull, m_speed;
  logic [N-1:0] m_otype, m_odr, m_idr, m_conf;
  int cat [N];

  // returns {clash, defined, level}; cat_o: 2=R2 3=R3 4=R4 5=R5 6=R6
  function automatic logic [2:0] ref_pin(input logic [1:0] md, input logic ot,
      input logic [1:0] pl, input logic od, input logic cn, input logic hi,
      output int cat_o);
    logic outm, clash, seen_disc;
    outm = (md == 2'b01);
    clash = cn && outm && (!ot || hi);
    seen_disc = !cn || clash;
    cat_o = clash ? 6 : (outm ? ((!ot || !od) ? 2 : 3) : 4);
    if (outm && (!ot || !od)) return {clash, 1'b1, od};
    if (seen_disc) begin
      if (pl == 2'b01) return {clash, 2'b11};
      if (pl == 2'b10) return {clash, 2'b10};
      cat_o = 5;
      return {clash, 2'b00};
    end
    return {clash, 1'b1, (outm ? 1'b0 : hi)};
  endfunction

  function automatic string tag(input int c);
    case (c)
      2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: model uses pre-edge state, then takes the write
  task automatic tick();
    logic [2:0] r;
    logic [N-1:0] nidr, nconf;
    int c;
    nidr = m_idr;
    for (int i = 0; i < N; i++) begin
      r = ref_pin(m_mode[2*i +: 2], m_otype[i], m_pull[2*i +: 2], m_odr[i],
                  ext_conn[i], ext_high[i], c);
      cat[i] = c;
      nconf[i] = r[2];
      if (r[1]) nidr[i] = r[0];
    end
    @(posedge clk);
    if (rst_n) begin
      m_idr = nidr;
      m_conf = nconf;
      if (bus_wr) begin
        case (bus_addr)
          10'h000: m_mode  = bus_wdata;
          10'h004: m_otype = bus_wdata[N-1:0];
          10'h008: m_speed = bus_wdata;
          10'h00C: m_pull  = bus_wdata;
          10'h014: m_odr   = bus_wdata[N-1:0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_pins();
    logic [31:0] d;
    for (int i = 0; i < N; i++)
      chk(tag(cat[i]), {31'b0, pin_out[i]}, {31'b0, m_idr[i]});
    chk("R6", {16'b0, pin_conflict}, {16'b0, m_conf});
    rd(10'h010, d);
    chk("R9", d, {16'b0, m_idr});
  endtask

  initial begin
    logic [31:0] d;
    m_mode = 0; m_pull = 0; m_speed = 0; m_otype = 0; m_odr = 0;
    m_idr = 0; m_conf = 0;
    for (int i = 0; i < N; i++) cat[i] = 5;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk("R8", {16'b0, pin_out}, 32'h0);
    chk("R8", {16'b0, pin_conflict}, 32'h0);
    foreach (d[k]) ;
    for (int a = 0; a < 6; a++) begin
      rd(10'(a * 4), d);
      chk("R8", d, 32'h0);
    end

    // R1: codes 10 and 11 behave as input (connected low reads 0 despite odr=1)
    ext_conn = 16'h0003; ext_high = 16'h0000;
    wr(10'h014, 32'h0000_0003);
    wr(10'h000, 32'h0000_000E); // pin0 code 10, pin1 code 11
    tick();
    chk("R1", {30'b0, pin_out[1:0]}, 32'h0);
    wr(10'h000, 32'h0000_0005); // both code 01: push-pull outputs
    tick();
    chk("R1", {30'b0, pin_out[1:0]}, 32'h3);
    check_pins();

    // R9: external change visible only after one edge
    wr(10'h000, 32'h0);
    tick();
    ext_conn = 16'hFFFF; ext_high = 16'hA5A5;
    #0.5;
    chk("R9", {16'b0, pin_out}, {16'b0, m_idr});
    tick();
    chk("R9", {16'b0, pin_out}, 32'h0000_A5A5);

    // R5: disconnect without pull holds previous level
    ext_conn = 16'h0;
    tick(); tick();
    chk("R5", {16'b0, pin_out}, 32'h0000_A5A5);

    // R7: ignored writes
    wr(10'h01C, 32'hFFFF_FFFF); wr(10'h020, 32'hFFFF_FFFF);
    wr(10'h024, 32'hFFFF_FFFF); wr(10'h02C, 32'hFFFF_FFFF);
    wr(10'h010, 32'h0000_5A5A);
    tick();
    chk("R7", {16'b0, pin_out}, 32'h0000_A5A5);
    rd(10'h01C, d); chk("R7", d, 32'h0);
    rd(10'h020, d); chk("R7", d, 32'h0);
    rd(10'h024, d); chk("R7", d, 32'h0);
    rd(10'h02C, d); chk("R7", d, 32'h0);
    rd(10'h000, d); chk("R7", d, m_mode);
    rd(10'h004, d); chk("R7", d, {16'b0, m_otype});
    rd(10'h00C, d); chk("R7", d, m_pull);
    rd(10'h014, d); chk("R7", d, {16'b0, m_odr});
    wr(10'h008, 32'hDEAD_BEEF);
    rd(10'h008, d); chk("R7", d, 32'hDEAD_BEEF);

    // R3/R6 directed: open-drain odr=1 with pulls and drives
    wr(10'h000, 32'h5555_5555);
    wr(10'h004, 32'h0000_FFFF);
    wr(10'h014, 32'h0000_FFFF);
    wr(10'h00C, 32'h0000_0009); // pin0 pull-up, pin1 pull-down
    ext_conn = 16'h000C; ext_high = 16'h0008; // pin2 low, pin3 high (clash)
    tick();
    chk("R3", {28'b0, pin_out[3:0]}, {28'b0, m_idr[3:0]});
    chk("R6", {16'b0, pin_conflict}, 32'h0000_0008);
    check_pins();

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int sel;
      ext_conn = 16'($urandom); ext_high = 16'($urandom);
      sel = $urandom_range(0, 4);
      case (sel)
        0: wr(10'h000, $urandom);
        1: wr(10'h004, $urandom);
        2: wr(10'h00C, $urandom);
        3: wr(10'h014, $urandom);
        default: tick();
      endcase
      tick();
      check_pins();
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule